// File: doc/BRIEF.md
# Descriptor Ring Walker for a Single DMA Channel

This block steps through a circular list of transfer descriptors kept in system memory for one DMA channel. Each descriptor is four 32-bit words. Once the channel is switched on, the block reads the descriptor at the ring's base address as one four-beat incrementing read burst. It hands the source address, destination address, byte length and flag bits to a separate data mover, then waits for the mover to report that it has finished.

When the mover finishes, the block writes the number of bytes actually moved back into the length word of that descriptor. It then goes on to the next descriptor, 16 bytes further on. If the descriptor just retired carries the wrap flag, it goes back to the base instead. The end of the ring is therefore marked inside memory, not by a programmed count.

A bus error response stops the walk and raises a sticky error flag. The flag is cleared by a single-cycle clear input. Clearing the enable lets the descriptor in progress finish, including its write-back, and then parks the block. Whenever the block starts again from rest, it starts at the base address.

Top module: `dring_fetch`

## Requirements
- R1: After reset, no bus request is made, no mover start is given, and the error flag is low.
- R2: A descriptor is read as four read beats with the burst flag high, at the descriptor address plus 0x0, 0x4, 0x8 and 0xC, in that order.
- R3: The first descriptor fetched after the block leaves rest is at the base address.
- R4: After a fetch completes, mover start is high for exactly one cycle. The mover fields are taken unaltered from the descriptor: source from word 0, length from bits 15:0 of word 1, destination from word 2, and flags from bits 31:28 of word 3 as {W, L, I, F}, with W at bit 31. Addresses may be at any byte offset.
- R5: After the mover reports done, the block makes one single write with the burst flag low, to the descriptor address plus 0x4. The data is the count reported by the mover, zero-extended to 32 bits, including a count smaller than the programmed length.
- R6: When the retired descriptor has W = 0, the next fetch is at its address plus 16.
- R7: When the retired descriptor has W = 1, the next fetch is at the base address.
- R8: When enable is low, the descriptor in progress still completes, including its write-back, and no further fetch follows. Enabling again starts at the base.
- R9: An error response on any beat of a fetch or a write-back stops the block and sets the error flag. While the flag is set, the block makes no bus request and gives no mover start, even with enable high. A write-back that draws an error leaves the length word unchanged.
- R10: A clear pulse drops the error flag. If enable is high, the next fetch is at the base.
- R11: While a request is not accepted, the request, address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| base_i | input | ADDR_W | Ring base address |
| err_clr_i | input | 1 | Pulse that clears the error flag |
| err_o | output | 1 | Sticky bus error flag |
| bus_req_o | output | 1 | Bus request, valid for the current beat |
| bus_write_o | output | 1 | 1 = write beat, 0 = read beat |
| bus_burst4_o | output | 1 | Beat belongs to a four-beat incrementing burst |
| bus_addr_o | output | ADDR_W | Beat address |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Beat completes this cycle |
| bus_err_i | input | 1 | Error response, valid with ready |
| bus_rdata_i | input | 32 | Read data, valid with ready |
| mv_start_o | output | 1 | One-cycle start to the mover |
| mv_src_o | output | ADDR_W | Source address for the mover |
| mv_dst_o | output | ADDR_W | Destination address for the mover |
| mv_len_o | output | LEN_W | Byte length for the mover |
| mv_flags_o | output | 4 | Descriptor flags {W, L, I, F} |
| mv_done_i | input | 1 | Mover finished; count valid |
| mv_count_i | input | LEN_W | Bytes actually moved |

## Verification
The assertions assume that the bus slave raises ready only while a request is pending, and that an error response comes only together with ready. The bench's slave model follows both rules, including when it inserts wait states. They also assume that mover done arrives only after a start, as a one-cycle pulse. The bench's mover model waits at least two cycles after the start before giving done, and drops it on the next cycle. The ring in memory is kept well below the 256-entry limit, and the base is word-aligned, so every beat address falls on a word.

// File: rtl/dring_pkg.sv
package dring_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_ISSUE,
      ST_WAIT,
      ST_WBACK,
      ST_ADV
   } dring_state_e;

   localparam int WORD_W     = 32;
   localparam int DESC_WORDS = 4;
   localparam int FLAG_HI    = 31;
   localparam int FLAG_LO    = 28;
   localparam int FLAG_W     = FLAG_HI - FLAG_LO + 1;
   localparam int WRAP_BIT   = FLAG_HI;
   localparam logic [1:0] LEN_WORD = 2'd1;

endpackage

// File: rtl/dring_addr_gen.sv
module dring_addr_gen #(
   parameter int ADDR_W       = 32,
   parameter int IDX_W        = 8,
   parameter bit RING_ALIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              step_i,
   input  logic              wrap_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [1:0]        beat_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int OFF_W = IDX_W + 4;

   logic [IDX_W-1:0]  idx_q;
   logic [OFF_W-1:0]  offset;
   logic [ADDR_W-1:0] desc_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (step_i) begin
         idx_q <= wrap_i ? '0 : idx_q + 1'b1;
      end
   end

   assign offset = {idx_q, 4'b0000};

   generate
      if (RING_ALIGNED) begin : g_concat
         assign desc_addr = {base_i[ADDR_W-1:OFF_W], offset};
      end else begin : g_add
         assign desc_addr = base_i + ADDR_W'(offset);
      end
   endgenerate

   assign addr_o = desc_addr + ADDR_W'({beat_i, 2'b00});

endmodule

// File: rtl/dring_desc_store.sv
module dring_desc_store
   import dring_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [1:0]        beat_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [ADDR_W-1:0] src_o,
   output logic [ADDR_W-1:0] dst_o,
   output logic [LEN_W-1:0]  len_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic              wrap_o
);

   generate
      for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (cap_i && (beat_i == 2'(g))) begin
               q <= word_i;
            end
         end
      end
   endgenerate

   assign src_o   = g_word[0].q[ADDR_W-1:0];
   assign len_o   = g_word[1].q[LEN_W-1:0];
   assign dst_o   = g_word[2].q[ADDR_W-1:0];
   assign flags_o = g_word[3].q[FLAG_HI:FLAG_LO];
   assign wrap_o  = g_word[3].q[WRAP_BIT];

   generate
      if (LEN_W < WORD_W) begin : g_len_spare
         logic unused_len;
         assign unused_len = ^g_word[1].q[WORD_W-1:LEN_W];
      end
      if (ADDR_W < WORD_W) begin : g_addr_spare
         logic unused_addr;
         assign unused_addr = ^{g_word[0].q[WORD_W-1:ADDR_W], g_word[2].q[WORD_W-1:ADDR_W]};
      end
   endgenerate

   logic unused_ctrl;
   assign unused_ctrl = ^g_word[3].q[FLAG_LO-1:0];

endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
   import dring_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             err_clr_i,
   input  logic             bus_ready_i,
   input  logic             bus_err_i,
   input  logic             mv_done_i,
   input  logic [LEN_W-1:0] mv_count_i,
   output logic [1:0]       beat_o,
   output logic             cap_o,
   output logic             bus_req_o,
   output logic             bus_write_o,
   output logic             bus_burst4_o,
   output logic             mv_start_o,
   output logic             idx_clr_o,
   output logic             idx_step_o,
   output logic             err_o,
   output logic [LEN_W-1:0] count_o
);

   dring_state_e     state_q, state_d;
   logic [1:0]       beat_q, beat_d;
   logic             err_q;
   logic [LEN_W-1:0] count_q;
   logic             fault;

   assign fault = bus_req_o && bus_ready_i && bus_err_i;

   always_comb begin
      state_d = state_q;
      beat_d  = beat_q;
      unique case (state_q)
         ST_IDLE: begin
            beat_d = '0;
            if (en_i && !err_q) state_d = ST_FETCH;
         end
         ST_FETCH: begin
            if (bus_ready_i) begin
               if (bus_err_i) begin
                  state_d = ST_IDLE;
               end else if (beat_q == 2'd3) begin
                  state_d = ST_ISSUE;
                  beat_d  = '0;
               end else begin
                  beat_d = beat_q + 2'd1;
               end
            end
         end
         ST_ISSUE: state_d = ST_WAIT;
         ST_WAIT: begin
            if (mv_done_i) state_d = ST_WBACK;
         end
         ST_WBACK: begin
            if (bus_ready_i) state_d = bus_err_i ? ST_IDLE : ST_ADV;
         end
         ST_ADV: state_d = en_i ? ST_FETCH : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         err_q   <= 1'b0;
         count_q <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
         if (fault) begin
            err_q <= 1'b1;
         end else if (err_clr_i) begin
            err_q <= 1'b0;
         end
         if ((state_q == ST_WAIT) && mv_done_i) begin
            count_q <= mv_count_i;
         end
      end
   end

   assign bus_req_o    = (state_q == ST_FETCH) || (state_q == ST_WBACK);
   assign bus_write_o  = (state_q == ST_WBACK);
   assign bus_burst4_o = (state_q == ST_FETCH);
   assign beat_o       = (state_q == ST_WBACK) ? LEN_WORD : beat_q;
   assign cap_o        = (state_q == ST_FETCH) && bus_ready_i && !bus_err_i;
   assign mv_start_o   = (state_q == ST_ISSUE);
   assign idx_clr_o    = (state_q == ST_IDLE);
   assign idx_step_o   = (state_q == ST_ADV);
   assign err_o        = err_q;
   assign count_o      = count_q;

endmodule

// File: rtl/dring_fetch.sv
module dring_fetch
   import dring_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LEN_W        = 16,
   parameter int IDX_W        = 8,
   parameter bit RING_ALIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              err_clr_i,
   output logic              err_o,
   output logic              bus_req_o,
   output logic              bus_write_o,
   output logic              bus_burst4_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [31:0]       bus_wdata_o,
   input  logic              bus_ready_i,
   input  logic              bus_err_i,
   input  logic [31:0]       bus_rdata_i,
   output logic              mv_start_o,
   output logic [ADDR_W-1:0] mv_src_o,
   output logic [ADDR_W-1:0] mv_dst_o,
   output logic [LEN_W-1:0]  mv_len_o,
   output logic [3:0]        mv_flags_o,
   input  logic              mv_done_i,
   input  logic [LEN_W-1:0]  mv_count_i
);

   localparam int OFF_W = IDX_W + 4;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("IDX_W must lie in 1..8 (ring of at most 4096 bytes)");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("LEN_W must lie in 1..16");
      end
      if (ADDR_W <= OFF_W || ADDR_W > WORD_W) begin : g_bad_addr
         $error("ADDR_W must exceed the ring offset width and fit a word");
      end
   endgenerate

   logic [1:0]       beat;
   logic             cap;
   logic             idx_clr;
   logic             idx_step;
   logic             wrap;
   logic [LEN_W-1:0] count;

   dring_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .err_clr_i    (err_clr_i),
      .bus_ready_i  (bus_ready_i),
      .bus_err_i    (bus_err_i),
      .mv_done_i    (mv_done_i),
      .mv_count_i   (mv_count_i),
      .beat_o       (beat),
      .cap_o        (cap),
      .bus_req_o    (bus_req_o),
      .bus_write_o  (bus_write_o),
      .bus_burst4_o (bus_burst4_o),
      .mv_start_o   (mv_start_o),
      .idx_clr_o    (idx_clr),
      .idx_step_o   (idx_step),
      .err_o        (err_o),
      .count_o      (count)
   );

   dring_addr_gen #(
      .ADDR_W       (ADDR_W),
      .IDX_W        (IDX_W),
      .RING_ALIGNED (RING_ALIGNED)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (idx_clr),
      .step_i (idx_step),
      .wrap_i (wrap),
      .base_i (base_i),
      .beat_i (beat),
      .addr_o (bus_addr_o)
   );

   dring_desc_store #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (cap),
      .beat_i  (beat),
      .word_i  (bus_rdata_i),
      .src_o   (mv_src_o),
      .dst_o   (mv_dst_o),
      .len_o   (mv_len_o),
      .flags_o (mv_flags_o),
      .wrap_o  (wrap)
   );

   assign bus_wdata_o = {{(WORD_W-LEN_W){1'b0}}, count};

endmodule

// File: rtl/dring_fetch_chk.sv
module dring_fetch_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req_o,
   input logic              bus_write_o,
   input logic              bus_burst4_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_ready_i,
   input logic              bus_err_i,
   input logic              mv_start_o,
   input logic              err_o,
   input logic              err_clr_i
);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_write_o));

   assert_fetch_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && bus_burst4_o |-> !bus_write_o);

   assert_beat_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && bus_burst4_o && bus_ready_i && !bus_err_i && (bus_addr_o[3:2] != 2'b11)
      |=> bus_req_o && bus_burst4_o && (bus_addr_o == $past(bus_addr_o) + ADDR_W'(4)));

   assert_wb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && bus_write_o |-> !bus_burst4_o && (bus_addr_o[3:0] == 4'h4));

   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start_o |=> !mv_start_o);

   assert_quiet_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !bus_req_o && !mv_start_o);

   assert_fault_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && bus_ready_i && bus_err_i |=> err_o);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !err_clr_i |=> err_o);

endmodule

bind dring_fetch dring_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_req_o    (bus_req_o),
   .bus_write_o  (bus_write_o),
   .bus_burst4_o (bus_burst4_o),
   .bus_addr_o   (bus_addr_o),
   .bus_ready_i  (bus_ready_i),
   .bus_err_i    (bus_err_i),
   .mv_start_o   (mv_start_o),
   .err_o        (err_o),
   .err_clr_i    (err_clr_i)
);

// File: tb/dring_fetch_bench.sv
module dring_fetch_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'h0000_0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic        err_clr_i = 1'b0;
   logic        err_o;
   logic        bus_req_o, bus_write_o, bus_burst4_o;
   logic [31:0] bus_addr_o, bus_wdata_o;
   logic        bus_ready_i = 1'b0;
   logic        bus_err_i = 1'b0;
   logic [31:0] bus_rdata_i = '0;
   logic        mv_start_o;
   logic [31:0] mv_src_o, mv_dst_o;
   logic [15:0] mv_len_o;
   logic [3:0]  mv_flags_o;
   logic        mv_done_i = 1'b0;
   logic [15:0] mv_count_i = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dring_fetch u_dring_fetch (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .base_i(BASE),
      .err_clr_i(err_clr_i), .err_o(err_o),
      .bus_req_o(bus_req_o), .bus_write_o(bus_write_o), .bus_burst4_o(bus_burst4_o),
      .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
      .bus_ready_i(bus_ready_i), .bus_err_i(bus_err_i), .bus_rdata_i(bus_rdata_i),
      .mv_start_o(mv_start_o), .mv_src_o(mv_src_o), .mv_dst_o(mv_dst_o),
      .mv_len_o(mv_len_o), .mv_flags_o(mv_flags_o),
      .mv_done_i(mv_done_i), .mv_count_i(mv_count_i)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   logic [31:0] mem [64];
   int          ws = 0;
   int          wcnt = 0;
   bit          err_en = 1'b0;
   bit          err_wr = 1'b0;
   logic [31:0] err_addr = '0;
   int          short_by = 0;

   logic [31:0] rd_addr [64];
   bit          rd_burst [64];
   int          rd_n = 0;
   logic [31:0] fa [64];
   int          f_n = 0;
   logic [31:0] wb_addr [64];
   logic [31:0] wb_data [64];
   int          wb_n = 0;
   logic [31:0] ms [64];
   logic [31:0] md [64];
   logic [15:0] ml [64];
   logic [3:0]  mf [64];
   int          mv_n = 0;
   bit          pend = 1'b0;
   int          dly = 0;

   function automatic int mi(input logic [31:0] a);
      return int'((a >> 2) & 32'd63);
   endfunction

   // bus slave model
   always @(negedge clk) begin
      bus_ready_i = 1'b0;
      bus_err_i   = 1'b0;
      if (rst_n && bus_req_o) begin
         if (wcnt < ws) begin
            wcnt++;
         end else begin
            wcnt = 0;
            bus_ready_i = 1'b1;
            if (err_en && bus_addr_o == err_addr && bus_write_o == err_wr) begin
               bus_err_i = 1'b1;
            end else if (bus_write_o) begin
               mem[mi(bus_addr_o)] = bus_wdata_o;
               if (wb_n < 64) begin
                  wb_addr[wb_n] = bus_addr_o;
                  wb_data[wb_n] = bus_wdata_o;
               end
               wb_n++;
            end
            if (!bus_write_o) begin
               bus_rdata_i = mem[mi(bus_addr_o)];
               if (rd_n < 64) begin
                  rd_addr[rd_n]  = bus_addr_o;
                  rd_burst[rd_n] = bus_burst4_o;
               end
               rd_n++;
               if (bus_addr_o[3:0] == 4'h0) begin
                  if (f_n < 64) fa[f_n] = bus_addr_o;
                  f_n++;
               end
            end
         end
      end else begin
         wcnt = 0;
      end
   end

   // mover model
   always @(negedge clk) begin
      if (mv_done_i) mv_done_i = 1'b0;
      if (rst_n && mv_start_o) begin
         if (mv_n < 64) begin
            ms[mv_n] = mv_src_o;
            md[mv_n] = mv_dst_o;
            ml[mv_n] = mv_len_o;
            mf[mv_n] = mv_flags_o;
         end
         mv_n++;
         pend = 1'b1;
         dly  = 2;
      end else if (pend) begin
         if (dly == 0) begin
            mv_done_i  = 1'b1;
            mv_count_i = (int'(mv_len_o) > short_by) ? mv_len_o - 16'(short_by) : 16'd0;
            pend = 1'b0;
         end else begin
            dly--;
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_logs();
      rd_n = 0;
      f_n  = 0;
      wb_n = 0;
      mv_n = 0;
   endtask

   // word 3 flags: bit31 W, bit30 L, bit29 I, bit28 F
   task automatic put_desc(input int i, input logic [31:0] src, input logic [15:0] len,
                           input logic [31:0] dst, input logic [3:0] flags);
      mem[mi(BASE) + i*4 + 0] = src;
      mem[mi(BASE) + i*4 + 1] = {16'h0, len};
      mem[mi(BASE) + i*4 + 2] = dst;
      mem[mi(BASE) + i*4 + 3] = {flags, 28'h0};
   endtask

   task automatic load_ring();
      put_desc(0, 32'h0000_1001, 16'h0040, 32'h0000_2003, 4'b0000);
      put_desc(1, 32'h0000_3002, 16'h0123, 32'h0000_4005, 4'b0010);
      put_desc(2, 32'h0000_5007, 16'h0008, 32'h0000_600E, 4'b1100);
   endtask

   task automatic t_reset();
      chk("R1 bus_req", 32'(bus_req_o), 32'd0);
      chk("R1 mv_start", 32'(mv_start_o), 32'd0);
      chk("R1 err", 32'(err_o), 32'd0);
   endtask

   task automatic t_ring();
      load_ring();
      clear_logs();
      en_i = 1'b1;
      for (int k = 0; k < 5000 && f_n < 5; k++) @(negedge clk);
      en_i = 1'b0;
      settle(80);
      chk("R3 first fetch", fa[0], BASE);
      chk("R6 second", fa[1], BASE + 32'd16);
      chk("R6 third", fa[2], BASE + 32'd32);
      chk("R7 wrap", fa[3], BASE);
      chk("R6 after wrap", fa[4], BASE + 32'd16);
      chk("R4 src0", ms[0], 32'h0000_1001);
      chk("R4 dst0", md[0], 32'h0000_2003);
      chk("R4 len1", 32'(ml[1]), 32'h123);
      chk("R4 flags1", 32'(mf[1]), 32'h2);
      chk("R4 src2", ms[2], 32'h0000_5007);
      chk("R4 dst2", md[2], 32'h0000_600E);
      chk("R4 flags2", 32'(mf[2]), 32'hC);
      chk("R5 wb addr0", wb_addr[0], BASE + 32'h4);
      chk("R5 wb addr2", wb_addr[2], BASE + 32'h24);
      chk("R5 wb data1", wb_data[1], 32'h0000_0123);
      chk("R8 fetches", 32'(f_n), 32'd5);
      chk("R8 writebacks", 32'(wb_n), 32'd5);
      chk("R1 idle req", 32'(bus_req_o), 32'd0);
   endtask

   task automatic t_early();
      load_ring();
      clear_logs();
      short_by = 5;
      en_i = 1'b1;
      for (int k = 0; k < 5000 && wb_n < 1; k++) @(negedge clk);
      en_i = 1'b0;
      settle(80);
      short_by = 0;
      chk("R4 len passed", 32'(ml[0]), 32'h40);
      chk("R5 short count", wb_data[0], 32'h0000_003B);
      chk("R5 mem word", mem[mi(BASE) + 1], 32'h0000_003B);
   endtask

   task automatic t_waits();
      load_ring();
      clear_logs();
      ws = 2;
      en_i = 1'b1;
      for (int k = 0; k < 5000 && rd_n < 4; k++) @(negedge clk);
      en_i = 1'b0;
      settle(100);
      ws = 0;
      for (int b = 0; b < 4; b++) begin
         chk("R2 beat addr", rd_addr[b], BASE + 32'(b*4));
         chk("R2 burst flag", 32'(rd_burst[b]), 32'd1);
      end
      chk("R11 data under waits", ms[0], 32'h0000_1001);
      chk("R11 length under waits", 32'(ml[0]), 32'h40);
   endtask

   task automatic t_disable();
      int q;
      load_ring();
      clear_logs();
      en_i = 1'b1;
      for (int k = 0; k < 5000 && mv_n < 2; k++) @(negedge clk);
      en_i = 1'b0;
      settle(80);
      chk("R8 fetch count", 32'(f_n), 32'd2);
      chk("R8 wb done", 32'(wb_n), 32'd2);
      q = f_n;
      settle(30);
      chk("R8 no more fetch", 32'(f_n), 32'(q));
      clear_logs();
      en_i = 1'b1;
      for (int k = 0; k < 5000 && f_n < 1; k++) @(negedge clk);
      chk("R8 restart base", fa[0], BASE);
      en_i = 1'b0;
      settle(80);
   endtask

   task automatic t_fetch_err();
      load_ring();
      clear_logs();
      err_addr = BASE + 32'h18;
      err_wr   = 1'b0;
      err_en   = 1'b1;
      en_i = 1'b1;
      for (int k = 0; k < 5000 && !err_o; k++) @(negedge clk);
      settle(30);
      chk("R9 err set", 32'(err_o), 32'd1);
      chk("R9 no req", 32'(bus_req_o), 32'd0);
      chk("R9 fetch stop", 32'(f_n), 32'd2);
      chk("R9 one mover", 32'(mv_n), 32'd1);
      chk("R9 one wb", 32'(wb_n), 32'd1);
      err_en = 1'b0;
      clear_logs();
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      for (int k = 0; k < 5000 && f_n < 1; k++) @(negedge clk);
      chk("R10 err cleared", 32'(err_o), 32'd0);
      chk("R10 restart base", fa[0], BASE);
      en_i = 1'b0;
      settle(80);
   endtask

   task automatic t_wb_err();
      load_ring();
      clear_logs();
      err_addr = BASE + 32'h4;
      err_wr   = 1'b1;
      err_en   = 1'b1;
      en_i = 1'b1;
      for (int k = 0; k < 5000 && !err_o; k++) @(negedge clk);
      settle(20);
      chk("R9 wb err set", 32'(err_o), 32'd1);
      chk("R9 no wb stored", 32'(wb_n), 32'd0);
      chk("R9 len word kept", mem[mi(BASE) + 1], 32'h0000_0040);
      chk("R9 single fetch", 32'(f_n), 32'd1);
      en_i = 1'b0;
      err_en = 1'b0;
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      settle(5);
      chk("R10 cleared idle", 32'(err_o), 32'd0);
      chk("R10 idle no req", 32'(bus_req_o), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      settle(5);
      rst_n = 1'b1;
      settle(2);
      t_reset();
      t_ring();
      t_early();
      t_waits();
      t_disable();
      t_fetch_err();
      t_wb_err();
      summary();
      $finish;
   end

endmodule